// File: doc/BRIEF.md
# Audio Filter Power-Up and Mute Sequencer

This block brings a digital audio filter device out of power-on in a fixed order and keeps its output silent until it has been configured. It waits for the device's master clock to be reported present. It then drives the device's active-low reset line through a set number of low pulses, separated by settle gaps. Next it waits for the upstream audio source to report a stable lock. Once lock is stable it asks an external serial shifter to send the device configuration, and repeats that transfer a set number of times. Only after the last transfer does it lift the active-high hardware mute and raise a ready flag.

After bring-up, a pulse on the rate-change input mutes the device again and repeats the full set of configuration transfers. Losing the master clock at any time sends the sequencer back to its idle state, and the whole sequence starts over when the clock returns. A build-time mute-enable parameter set to zero stops the block from ever asserting mute. In that case it keeps the same timing and handshakes.

Top module: `audio_bringup_seq`

## Requirements
- R1: While `mclk_ok` is low, `dev_rst_n` stays high, `cfg_req` and `ready` stay low, and `mute_out` is high. The first reset pulse begins on the cycle after `mclk_ok` is sampled high.
- R2: Each reset pulse holds `dev_rst_n` low for exactly `PULSE_CYC` clock cycles.
- R3: Exactly `NUM_PULSES` reset pulses are issued per bring-up. Consecutive pulses are separated by exactly `GAP_CYC` cycles with `dev_rst_n` high. No pulse follows the last one.
- R4: `cfg_req` is first raised only after `src_lock` has been high for `LOCK_CYC` consecutive sampled cycles (request visible on the cycle after that). A shorter high spell does not start a transfer.
- R5: `cfg_req` stays high until `cfg_done` is sampled high, then drops for at least one cycle. Exactly `NUM_SENDS` transfers are requested per configuration run.
- R6: With mute enabled, `mute_out` is high during reset pulses, lock wait and every transfer. It falls on the cycle after the final `cfg_done` is sampled.
- R7: `ready` rises one cycle after `mute_out` falls, and `ready` is never high while `mute_out` is high.
- R8: A `rate_chg` pulse while `ready` is high drops `ready` and raises `mute_out` on the next cycle, then reruns all `NUM_SENDS` transfers. A `rate_chg` pulse during a transfer has no effect on the transfer count.
- R9: `mclk_ok` low in any state returns all outputs to the R1 idle values on the next cycle. The full pulse sequence restarts when the clock returns, including when the clock drops in the middle of a pulse.
- R10: With `MUTE_EN` = 0, `mute_out` is never high. All other outputs behave exactly as with mute enabled.
- R11: Synchronous reset `rst` puts the block in the idle state of R1. If `mclk_ok` is high when reset is released, a new pulse sequence begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mclk_ok | input | 1 | Master clock to the device is present |
| src_lock | input | 1 | Upstream source reports lock |
| rate_chg | input | 1 | One-cycle flag: input sample rate changed |
| cfg_done | input | 1 | Serial shifter finished the current transfer |
| cfg_req | output | 1 | Request one configuration transfer |
| dev_rst_n | output | 1 | Device reset, active low |
| mute_out | output | 1 | Device hardware mute, active high |
| ready | output | 1 | Configuration complete and output unmuted |

## Verification
The bench measures every reset pulse and gap to the cycle. An off-by-one timer would show up as a pulse of `PULSE_CYC±1` cycles, and a miscounted loop as a fourth pulse or a missing one. It gives `src_lock` a high spell one cycle too short: a debounce that compares against the wrong limit would start a transfer early. It varies the `cfg_done` latency and injects rate changes both while live and in mid-transfer. A design that repeated too few sends, released mute before the last one, or counted a mid-transfer rate flag would show a wrong request count or an unmuted request. Clock loss is applied while live and in the middle of a pulse, where a sequencer that resumed instead of restarting would produce a short pulse. A second instance with mute disabled runs in lockstep to show that mute never rises there.

// File: rtl/bup_pkg.sv
package bup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LO,
        ST_RST_GAP,
        ST_LOCK_WAIT,
        ST_XFER,
        ST_XFER_GAP,
        ST_UNMUTE,
        ST_LIVE
    } seq_state_t;

    typedef struct packed {
        logic dev_rst_n;
        logic mute;
        logic req;
        logic ready;
    } seq_out_t;

    // Bits needed to hold values 0..maxv
    function automatic int unsigned cnt_w(int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    // Moore output decode of the sequencer state
    function automatic seq_out_t decode(seq_state_t s, logic mute_en);
        seq_out_t o;
        o.dev_rst_n = (s != ST_RST_LO);
        o.req       = (s == ST_XFER);
        o.ready     = (s == ST_LIVE);
        o.mute      = mute_en && !((s == ST_UNMUTE) || (s == ST_LIVE));
        return o;
    endfunction

endpackage

// File: rtl/bup_timer.sv
module bup_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R2: once expired the timer holds at zero until reloaded
    a_r2_timer_holds_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/bup_count.sv
module bup_count #(
    parameter int unsigned MAXV = 3,
    localparam int unsigned W   = bup_pkg::cnt_w(MAXV)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    // R3 / R5: the pulse and transfer tallies never pass their limit
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        value <= W'(MAXV));

endmodule

// File: rtl/bup_lock_filter.sv
module bup_lock_filter #(
    parameter int unsigned HOLD = 16,
    localparam int unsigned W   = bup_pkg::cnt_w(HOLD)
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_in,
    output logic stable
);
    logic [W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !lock_in) begin
            run <= '0;
        end else if (run != W'(HOLD)) begin
            run <= run + 1'b1;
        end
    end

    assign stable = (run == W'(HOLD));

    // R4: a low lock input always clears the stable indication next cycle
    a_r4_lock_drop_clears: assert property (@(posedge clk) disable iff (rst)
        !lock_in |=> !stable);

endmodule

// File: rtl/audio_bringup_seq.sv
module audio_bringup_seq #(
    parameter int unsigned PULSE_CYC  = 100000,
    parameter int unsigned GAP_CYC    = 100000,
    parameter int unsigned NUM_PULSES = 3,
    parameter int unsigned NUM_SENDS  = 2,
    parameter int unsigned LOCK_CYC   = 20000,
    parameter bit          MUTE_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_ok,
    input  logic src_lock,
    input  logic rate_chg,
    input  logic cfg_done,
    output logic cfg_req,
    output logic dev_rst_n,
    output logic mute_out,
    output logic ready
);
    import bup_pkg::*;

    localparam int unsigned TMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int unsigned TW   = cnt_w(TMAX);
    localparam int unsigned PW   = cnt_w(NUM_PULSES);
    localparam int unsigned XW   = cnt_w(NUM_SENDS);

    seq_state_t st, nxt;
    seq_out_t   outs;

    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          pc_clr, pc_inc, xc_clr, xc_inc;
    logic [PW-1:0] pcnt;
    logic [XW-1:0] xcnt;
    logic          lock_ok;

    bup_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    bup_count #(.MAXV(NUM_PULSES)) u_pulses (
        .clk(clk), .rst(rst), .clr(pc_clr), .inc(pc_inc), .value(pcnt)
    );

    bup_count #(.MAXV(NUM_SENDS)) u_sends (
        .clk(clk), .rst(rst), .clr(xc_clr), .inc(xc_inc), .value(xcnt)
    );

    bup_lock_filter #(.HOLD(LOCK_CYC)) u_lock (
        .clk(clk), .rst(rst), .lock_in(src_lock), .stable(lock_ok)
    );

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        pc_clr   = 1'b0;
        pc_inc   = 1'b0;
        xc_clr   = 1'b0;
        xc_inc   = 1'b0;
        if (!mclk_ok) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    nxt      = ST_RST_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                    pc_clr   = 1'b1;
                end
                ST_RST_LO: begin
                    if (tmr_done) begin
                        pc_inc = 1'b1;
                        if (pcnt == PW'(NUM_PULSES - 1)) begin
                            nxt    = ST_LOCK_WAIT;
                            xc_clr = 1'b1;
                        end else begin
                            nxt      = ST_RST_GAP;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(GAP_CYC - 1);
                        end
                    end
                end
                ST_RST_GAP: begin
                    if (tmr_done) begin
                        nxt      = ST_RST_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(PULSE_CYC - 1);
                    end
                end
                ST_LOCK_WAIT: begin
                    if (lock_ok) nxt = ST_XFER;
                end
                ST_XFER: begin
                    if (cfg_done) begin
                        xc_inc = 1'b1;
                        nxt    = (xcnt == XW'(NUM_SENDS - 1)) ? ST_UNMUTE : ST_XFER_GAP;
                    end
                end
                ST_XFER_GAP: nxt = ST_XFER;
                ST_UNMUTE:   nxt = ST_LIVE;
                ST_LIVE: begin
                    if (rate_chg) begin
                        nxt    = ST_LOCK_WAIT;
                        xc_clr = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    assign outs      = decode(st, MUTE_EN);
    assign dev_rst_n = outs.dev_rst_n;
    assign mute_out  = outs.mute;
    assign cfg_req   = outs.req;
    assign ready     = outs.ready;

    // R1: a reset pulse only begins after the clock was seen present
    a_r1_no_pulse_without_clock: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_rst_n) |-> $past(mclk_ok));

    // R9: clock loss forces the idle outputs on the next cycle
    a_r9_clock_loss_idle: assert property (@(posedge clk) disable iff (rst)
        !mclk_ok |=> (dev_rst_n && !cfg_req && !ready));

    // R6: every transfer request happens under mute when muting is enabled
    a_r6_req_under_mute: assert property (@(posedge clk) disable iff (rst)
        (MUTE_EN && cfg_req) |-> mute_out);

    // R7: ready never coexists with mute, and mute was already low before ready rose
    a_r7_ready_unmuted: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mute_out);
    a_r7_ready_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(!mute_out));

    // R5: an acknowledged request drops on the following cycle
    a_r5_req_drops_after_done: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_done) |=> !cfg_req);

    // R10: mute stays low when muting is disabled
    a_r10_mute_disabled: assert property (@(posedge clk) disable iff (rst)
        !MUTE_EN |-> !mute_out);

endmodule

// File: tb/sim_audio_bringup_seq.sv
module sim_audio_bringup_seq;

    localparam int unsigned PULSE = 8;
    localparam int unsigned GAP   = 5;
    localparam int unsigned NP    = 3;
    localparam int unsigned NS    = 2;
    localparam int unsigned LOCKC = 4;
    localparam int unsigned GUARD = 2000;

    // Reprogramming scenarios: cfg_done latency and whether rate_chg is pulsed mid-transfer
    localparam int NROWS = 4;
    localparam int ROW_DELAY [NROWS] = '{0, 1, 3, 6};
    localparam bit ROW_RATE  [NROWS] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst, mclk_ok, src_lock, rate_chg, cfg_done;
    logic cfg_req, dev_rst_n, mute_out, ready;
    logic m_req, m_rst_n, m_mute, m_ready;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    audio_bringup_seq #(.PULSE_CYC(PULSE), .GAP_CYC(GAP), .NUM_PULSES(NP),
        .NUM_SENDS(NS), .LOCK_CYC(LOCKC), .MUTE_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .mclk_ok(mclk_ok), .src_lock(src_lock),
        .rate_chg(rate_chg), .cfg_done(cfg_done), .cfg_req(cfg_req),
        .dev_rst_n(dev_rst_n), .mute_out(mute_out), .ready(ready));

    audio_bringup_seq #(.PULSE_CYC(PULSE), .GAP_CYC(GAP), .NUM_PULSES(NP),
        .NUM_SENDS(NS), .LOCK_CYC(LOCKC), .MUTE_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .mclk_ok(mclk_ok), .src_lock(src_lock),
        .rate_chg(rate_chg), .cfg_done(cfg_done), .cfg_req(m_req),
        .dev_rst_n(m_rst_n), .mute_out(m_mute), .ready(m_ready));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(dev_rst_n == 1'b1, req, dev_rst_n, 1);
        check(mute_out == 1'b1, req, mute_out, 1);
        check(cfg_req == 1'b0, req, cfg_req, 0);
        check(ready == 1'b0, req, ready, 0);
        check(m_mute == 1'b0, "R10", m_mute, 0);
    endtask

    // Called on the negedge at which mclk_ok was just raised (state idle)
    task automatic run_pulses();
        int hi, lo, g;
        @(negedge clk);
        for (int p = 0; p < int'(NP); p++) begin
            hi = 0; g = 0;
            while (dev_rst_n && g < GUARD) begin hi++; g++; @(negedge clk); end
            check(hi == ((p == 0) ? 0 : int'(GAP)), "R3", hi, (p == 0) ? 0 : GAP);
            lo = 0; g = 0;
            while (!dev_rst_n && g < GUARD) begin
                check(mute_out == 1'b1, "R6", mute_out, 1);
                lo++; g++; @(negedge clk);
            end
            check(lo == int'(PULSE), "R2", lo, PULSE);
        end
    endtask

    // Serve one full configuration run; returns when ready has risen
    task automatic serve_all(input int dly, input bit rate_mid);
        int g, extra;
        for (int t = 0; t < int'(NS); t++) begin
            g = 0;
            while (!cfg_req && g < GUARD) begin g++; @(negedge clk); end
            check(cfg_req == 1'b1, "R5", cfg_req, 1);
            check(mute_out == 1'b1, "R6", mute_out, 1);
            check(ready == 1'b0, "R7", ready, 0);
            check(m_mute == 1'b0, "R10", m_mute, 0);
            if (rate_mid && t == 0) begin
                rate_chg = 1'b1;
                @(negedge clk);
                rate_chg = 1'b0;
            end
            repeat (dly) @(negedge clk);
            check(cfg_req == 1'b1, "R5", cfg_req, 1);
            cfg_done = 1'b1;
            @(negedge clk);
            cfg_done = 1'b0;
            check(cfg_req == 1'b0, "R5", cfg_req, 0);
            if (t == int'(NS) - 1) begin
                check(mute_out == 1'b0, "R6", mute_out, 0);
                check(ready == 1'b0, "R7", ready, 0);
                @(negedge clk);
                check(ready == 1'b1, "R7", ready, 1);
                check(m_ready == 1'b1, "R10", m_ready, 1);
                check(mute_out == 1'b0, "R7", mute_out, 0);
            end
        end
        extra = 0;
        repeat (6) begin @(negedge clk); if (cfg_req) extra++; end
        check(extra == 0, "R5", extra, 0);
        check(ready == 1'b1, "R8", ready, 1);
    endtask

    initial begin
        int n, g;
        rst = 1'b1; mclk_ok = 1'b0; src_lock = 1'b0; rate_chg = 1'b0; cfg_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R11");

        // R1: no pulse while the clock is absent
        n = 0;
        repeat (20) begin @(negedge clk); if (!dev_rst_n || cfg_req) n++; end
        check(n == 0, "R1", n, 0);
        check_idle("R1");

        mclk_ok = 1'b1;
        run_pulses();

        // R3: no extra pulse, and R4: no request without lock
        n = 0;
        repeat (12) begin @(negedge clk); if (!dev_rst_n) n++; end
        check(n == 0, "R3", n, 0);
        check(cfg_req == 1'b0, "R4", cfg_req, 0);

        // R4: a lock spell one cycle too short must not start a transfer
        src_lock = 1'b1;
        repeat (LOCKC - 1) @(negedge clk);
        src_lock = 1'b0;
        n = 0;
        repeat (8) begin @(negedge clk); if (cfg_req) n++; end
        check(n == 0, "R4", n, 0);

        // R4: a full spell starts the request after LOCKC sampled cycles
        src_lock = 1'b1;
        n = 0; g = 0;
        @(negedge clk);
        while (!cfg_req && g < GUARD) begin n++; g++; @(negedge clk); end
        check(n == int'(LOCKC), "R4", n, LOCKC);

        serve_all(2, 1'b0);

        // R8: rate changes while live, walked from the table
        for (int r = 0; r < NROWS; r++) begin
            rate_chg = 1'b1;
            @(negedge clk);
            rate_chg = 1'b0;
            check(mute_out == 1'b1, "R8", mute_out, 1);
            check(ready == 1'b0, "R8", ready, 0);
            check(m_mute == 1'b0, "R10", m_mute, 0);
            serve_all(ROW_DELAY[r], ROW_RATE[r]);
        end

        // R9: clock loss while live
        mclk_ok = 1'b0;
        @(negedge clk);
        check_idle("R9");
        n = 0;
        repeat (5) begin @(negedge clk); if (!dev_rst_n) n++; end
        check(n == 0, "R9", n, 0);
        mclk_ok = 1'b1;
        run_pulses();
        serve_all(0, 1'b0);

        // R9: clock loss in the middle of a pulse, then a full restart
        mclk_ok = 1'b0;
        @(negedge clk);
        mclk_ok = 1'b1;
        @(negedge clk);
        check(dev_rst_n == 1'b0, "R9", dev_rst_n, 0);
        repeat (2) @(negedge clk);
        mclk_ok = 1'b0;
        @(negedge clk);
        check_idle("R9");
        mclk_ok = 1'b1;
        run_pulses();
        serve_all(1, 1'b0);

        // R11: synchronous reset while live
        rst = 1'b1;
        @(negedge clk);
        check_idle("R11");
        rst = 1'b0;
        @(negedge clk);
        check(dev_rst_n == 1'b0, "R11", dev_rst_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule